// File: doc/BRIEF.md
# Interrupt Vector Dispatcher

This block turns interrupt requests into control transfers for a small processor. A table indexed by interrupt id holds, for each id, a handler destination address and a memory address where the interrupted instruction pointer is stored. When a request is taken, the block first issues a memory write that stores the current instruction pointer at the entry's save address. It then issues a one-cycle instruction-pointer load to the entry's destination. During both steps it raises a bypass signal, so the memory barrier logic lets the transfer through no matter where execution was.

Requests come from two kinds of source. External requests are level inputs, and they are taken only while a global enable is set. Fault requests are pulses, for example a protection violation or an illegal instruction. Each fault pulse is latched as a sticky pending bit and is taken whatever the enable holds. A decoded null opcode does not stop the processor. It raises the illegal-instruction id instead. The table is filled through a small write port while the dispatcher is idle.

The dispatcher has three states:
- `ST_IDLE` moves to `ST_SAVE` when anything is pending, and captures the winning id, its entry and the current instruction pointer.
- `ST_SAVE` holds the write request until the memory answers ready, then moves to `ST_JUMP`.
- `ST_JUMP` lasts one cycle, loads the instruction pointer, clears the served id's pending bit and returns to `ST_IDLE`.

Top module: `idt_dispatcher`

## Requirements
- R1: Synchronous reset clears all pending bits, the global enable and every entry valid bit, and puts the dispatcher in ST_IDLE with `mem_wr_req`, `pc_load` and `barrier_bypass` low.
- R2: A write on the table port (`cfg_we`) updates entry `cfg_id`. Field code 0 sets the destination, code 1 sets the save address, and code 2 sets the valid bit from `cfg_data[0]`. Code 3 has no effect.
- R3: On dispatch, `mem_wr_req` rises with `mem_wr_addr` equal to the entry's save address and `mem_wr_data` equal to `cur_pc` as sampled in the cycle the dispatch started. Request, address and data stay unchanged until `mem_wr_ready` is seen.
- R4: In the cycle after the write handshake, `pc_load` is high for exactly one cycle with `pc_value` equal to the entry's destination.
- R5: `barrier_bypass` is high during the save write and the instruction-pointer load, and low otherwise.
- R6: When several ids are pending at once, the lowest id is served first. The others stay pending and are served afterwards.
- R7: External requests are taken only while the global enable, written through `en_we`/`en_data`, is 1.
- R8: A fault pulse on `fault_req` is held pending until its id is dispatched, and it is taken even while the global enable is 0.
- R9: A pulse on `null_op` raises the pending bit of the illegal-instruction id (parameter `ILL_ID`, default 6).
- R10: A request whose entry valid bit is 0 uses the destination and save address of entry 0.
- R11: Table writes presented while the dispatcher is not in ST_IDLE are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Table write strobe |
| cfg_id | input | 4 | Entry to write |
| cfg_field | input | 2 | 0 destination, 1 save address, 2 valid bit |
| cfg_data | input | 16 | Write data |
| en_we | input | 1 | Global enable write strobe |
| en_data | input | 1 | New global enable value |
| ext_req | input | 16 | External request levels, one per id |
| fault_req | input | 16 | Fault request pulses, one per id |
| null_op | input | 1 | Null opcode decoded, raises ILL_ID |
| cur_pc | input | 16 | Current instruction pointer |
| mem_wr_ready | input | 1 | Memory accepts the save write |
| mem_wr_req | output | 1 | Save write request |
| mem_wr_addr | output | 16 | Save write address |
| mem_wr_data | output | 16 | Saved instruction pointer |
| pc_load | output | 1 | Instruction pointer load strobe |
| pc_value | output | 16 | Handler destination |
| barrier_bypass | output | 1 | Skip memory barrier checks |

## Verification
The bench holds `mem_wr_ready` low for several cycles and changes `cur_pc` during that time. A design that let the request drop, or that sent the live pointer instead of the captured one, would store the wrong return address. Two faults are pulsed in the same cycle with the enable off. A design without sticky bits or without fixed priority would lose the higher id, serve the pair out of order, or ignore faults while disabled. Entries with the valid bit cleared, including one invalidated after use, must fall back to entry 0. A design that ignored the valid bit would jump to stale or zero addresses. A destination rewrite issued during a save must not change the jump target, which shows whether the idle-only write gate exists.

// File: rtl/idt_pkg.sv
package idt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SAVE = 2'd1,
        ST_JUMP = 2'd2
    } disp_state_t;

    typedef enum logic [1:0] {
        FLD_DEST  = 2'd0,
        FLD_SAVE  = 2'd1,
        FLD_VALID = 2'd2
    } cfg_field_t;
endpackage

// File: rtl/idt_vector_table.sv
module idt_vector_table #(
    parameter int NUM_IDS = 16,
    parameter int ID_W    = 4,
    parameter int ADDR_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [1:0]        wr_field,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [ID_W-1:0]   rd_id,
    output logic [ADDR_W-1:0] rd_dest,
    output logic [ADDR_W-1:0] rd_save
);
    import idt_pkg::*;

    logic [ADDR_W-1:0] dest_q [NUM_IDS];
    logic [ADDR_W-1:0] save_q [NUM_IDS];
    logic [NUM_IDS-1:0] valid_q;

    for (genvar g = 0; g < NUM_IDS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                dest_q[g]  <= '0;
                save_q[g]  <= '0;
                valid_q[g] <= 1'b0;
            end else if (wr_en && wr_id == ID_W'(g)) begin
                unique case (wr_field)
                    FLD_DEST:  dest_q[g]  <= wr_data;
                    FLD_SAVE:  save_q[g]  <= wr_data;
                    FLD_VALID: valid_q[g] <= wr_data[0];
                    default:   ;
                endcase
            end
        end
    end

    // invalid entry falls back to the default handler at id 0
    always_comb begin
        if (valid_q[rd_id]) begin
            rd_dest = dest_q[rd_id];
            rd_save = save_q[rd_id];
        end else begin
            rd_dest = dest_q[0];
            rd_save = save_q[0];
        end
    end
endmodule

// File: rtl/idt_pending.sv
module idt_pending #(
    parameter int NUM_IDS = 16,
    parameter int ID_W    = 4,
    parameter int ILL_ID  = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_we,
    input  logic               en_data,
    input  logic [NUM_IDS-1:0] ext_req,
    input  logic [NUM_IDS-1:0] fault_req,
    input  logic               null_op,
    input  logic               clr_en,
    input  logic [ID_W-1:0]    clr_id,
    output logic               any_pend,
    output logic [ID_W-1:0]    win_id
);
    localparam logic [NUM_IDS-1:0] ILL_MASK = NUM_IDS'(1) << ILL_ID;

    logic               enable_q;
    logic [NUM_IDS-1:0] sticky_q;
    logic [NUM_IDS-1:0] new_faults;
    logic [NUM_IDS-1:0] clr_mask;
    logic [NUM_IDS-1:0] live;

    always_comb begin
        new_faults = fault_req | (null_op ? ILL_MASK : '0);
        clr_mask   = clr_en ? (NUM_IDS'(1) << clr_id) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= 1'b0;
            sticky_q <= '0;
        end else begin
            if (en_we) enable_q <= en_data;
            sticky_q <= (sticky_q & ~clr_mask) | new_faults;
        end
    end

    always_comb begin
        live     = sticky_q | (enable_q ? ext_req : '0);
        any_pend = |live;
        win_id   = '0;
        for (int i = NUM_IDS - 1; i >= 0; i--) begin
            if (live[i]) win_id = ID_W'(i);
        end
    end
endmodule

// File: rtl/idt_dispatch_fsm.sv
module idt_dispatch_fsm #(
    parameter int ID_W   = 4,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              any_pend,
    input  logic [ID_W-1:0]   win_id,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] ent_dest,
    input  logic [ADDR_W-1:0] ent_save,
    input  logic              mem_wr_ready,
    output logic              idle,
    output logic              clr_en,
    output logic [ID_W-1:0]   clr_id,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [ADDR_W-1:0] mem_wr_data,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_value,
    output logic              barrier_bypass
);
    import idt_pkg::*;

    disp_state_t       state_q, state_d;
    logic [ID_W-1:0]   id_q;
    logic [ADDR_W-1:0] dest_q, save_q, pc_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any_pend)     state_d = ST_SAVE;
            ST_SAVE: if (mem_wr_ready) state_d = ST_JUMP;
            ST_JUMP:                   state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            id_q   <= '0;
            dest_q <= '0;
            save_q <= '0;
            pc_q   <= '0;
        end else if (state_q == ST_IDLE && any_pend) begin
            id_q   <= win_id;
            dest_q <= ent_dest;
            save_q <= ent_save;
            pc_q   <= cur_pc;
        end
    end

    always_comb begin
        idle           = 1'b0;
        clr_en         = 1'b0;
        mem_wr_req     = 1'b0;
        pc_load        = 1'b0;
        barrier_bypass = 1'b0;
        unique case (state_q)
            ST_IDLE: idle = 1'b1;
            ST_SAVE: begin
                mem_wr_req     = 1'b1;
                barrier_bypass = 1'b1;
            end
            ST_JUMP: begin
                pc_load        = 1'b1;
                clr_en         = 1'b1;
                barrier_bypass = 1'b1;
            end
            default: ;
        endcase
    end

    assign clr_id      = id_q;
    assign mem_wr_addr = save_q;
    assign mem_wr_data = pc_q;
    assign pc_value    = dest_q;

    // R3
    save_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_req && !mem_wr_ready) |=> (mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data)));
    // R4
    load_after_handshake_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load |-> $past(mem_wr_req && mem_wr_ready));
    // R4
    load_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !pc_load);
    // R5
    bypass_cover_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_req || pc_load) |-> barrier_bypass);
    // R5
    write_load_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_wr_req, pc_load}));
endmodule

// File: rtl/idt_dispatcher.sv
module idt_dispatcher #(
    parameter int NUM_IDS = 16,
    parameter int ADDR_W  = 16,
    parameter int ILL_ID  = 6,
    localparam int ID_W   = $clog2(NUM_IDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [ID_W-1:0]    cfg_id,
    input  logic [1:0]         cfg_field,
    input  logic [ADDR_W-1:0]  cfg_data,
    input  logic               en_we,
    input  logic               en_data,
    input  logic [NUM_IDS-1:0] ext_req,
    input  logic [NUM_IDS-1:0] fault_req,
    input  logic               null_op,
    input  logic [ADDR_W-1:0]  cur_pc,
    input  logic               mem_wr_ready,
    output logic               mem_wr_req,
    output logic [ADDR_W-1:0]  mem_wr_addr,
    output logic [ADDR_W-1:0]  mem_wr_data,
    output logic               pc_load,
    output logic [ADDR_W-1:0]  pc_value,
    output logic               barrier_bypass
);
    logic              idle;
    logic              any_pend;
    logic [ID_W-1:0]   win_id;
    logic              clr_en;
    logic [ID_W-1:0]   clr_id;
    logic [ADDR_W-1:0] ent_dest, ent_save;
    logic              tbl_we;

    // R11: table only writable while idle
    assign tbl_we = cfg_we && idle;

    idt_vector_table #(.NUM_IDS(NUM_IDS), .ID_W(ID_W), .ADDR_W(ADDR_W)) table_i (
        .clk(clk), .rst(rst),
        .wr_en(tbl_we), .wr_id(cfg_id), .wr_field(cfg_field), .wr_data(cfg_data),
        .rd_id(win_id), .rd_dest(ent_dest), .rd_save(ent_save)
    );

    idt_pending #(.NUM_IDS(NUM_IDS), .ID_W(ID_W), .ILL_ID(ILL_ID)) pend_i (
        .clk(clk), .rst(rst),
        .en_we(en_we), .en_data(en_data),
        .ext_req(ext_req), .fault_req(fault_req), .null_op(null_op),
        .clr_en(clr_en), .clr_id(clr_id),
        .any_pend(any_pend), .win_id(win_id)
    );

    idt_dispatch_fsm #(.ID_W(ID_W), .ADDR_W(ADDR_W)) fsm_i (
        .clk(clk), .rst(rst),
        .any_pend(any_pend), .win_id(win_id), .cur_pc(cur_pc),
        .ent_dest(ent_dest), .ent_save(ent_save), .mem_wr_ready(mem_wr_ready),
        .idle(idle), .clr_en(clr_en), .clr_id(clr_id),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .pc_load(pc_load), .pc_value(pc_value), .barrier_bypass(barrier_bypass)
    );

    // R11
    busy_cfg_block_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_req || pc_load) |-> !tbl_we);
endmodule

// File: tb/idt_dispatcher_tb_top.sv
module idt_dispatcher_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_id = '0;
    logic [1:0]  cfg_field = '0;
    logic [15:0] cfg_data = '0;
    logic        en_we = 1'b0, en_data = 1'b0;
    logic [15:0] ext_req = '0, fault_req = '0;
    logic        null_op = 1'b0;
    logic [15:0] cur_pc = '0;
    logic        mem_wr_ready = 1'b0;
    logic        mem_wr_req, pc_load, barrier_bypass;
    logic [15:0] mem_wr_addr, mem_wr_data, pc_value;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    idt_dispatcher dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_field(cfg_field),
        .cfg_data(cfg_data), .en_we(en_we), .en_data(en_data), .ext_req(ext_req),
        .fault_req(fault_req), .null_op(null_op), .cur_pc(cur_pc),
        .mem_wr_ready(mem_wr_ready), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .pc_load(pc_load), .pc_value(pc_value),
        .barrier_bypass(barrier_bypass)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cfg(input logic [3:0] id, input logic [1:0] f, input logic [15:0] d);
        cfg_we = 1; cfg_id = id; cfg_field = f; cfg_data = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic prog(input logic [3:0] id, input logic [15:0] dest, input logic [15:0] save);
        cfg(id, 2'd0, dest);
        cfg(id, 2'd1, save);
        cfg(id, 2'd2, 16'd1);
    endtask

    task automatic set_en(input logic v);
        en_we = 1; en_data = v;
        @(negedge clk);
        en_we = 0;
    endtask

    task automatic pulse_fault(input logic [15:0] m);
        fault_req = m;
        @(negedge clk);
        fault_req = '0;
    endtask

    // wait for save write, check it, stall with ready low while cur_pc moves
    task automatic wait_save(input logic [15:0] exp_save, input logic [15:0] exp_pc, input string tag);
        for (int i = 0; i < 20 && !mem_wr_req; i++) @(negedge clk);
        check(mem_wr_req, {tag, " save req"}, mem_wr_req, 1);
        check(mem_wr_addr == exp_save, {tag, " save addr"}, mem_wr_addr, exp_save);
        check(mem_wr_data == exp_pc, {tag, " saved pc"}, mem_wr_data, exp_pc);
        check(barrier_bypass, {tag, " R5 bypass in save"}, barrier_bypass, 1);
        cur_pc = 16'hDEAD;
        cyc(2);
        check(mem_wr_req && mem_wr_data == exp_pc && mem_wr_addr == exp_save,
              {tag, " R3 hold under stall"}, mem_wr_data, exp_pc);
    endtask

    task automatic do_jump(input logic [15:0] exp_dest, input string tag);
        mem_wr_ready = 1;
        @(negedge clk);
        mem_wr_ready = 0;
        check(pc_load && !mem_wr_req, {tag, " R4 load"}, pc_load, 1);
        check(pc_value == exp_dest, {tag, " R4 dest"}, pc_value, exp_dest);
        check(barrier_bypass, {tag, " R5 bypass in jump"}, barrier_bypass, 1);
        @(negedge clk);
        check(!pc_load, {tag, " R4 single cycle"}, pc_load, 0);
    endtask

    task automatic expect_quiet(input int n, input string tag);
        bit seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mem_wr_req || pc_load || barrier_bypass) seen = 1;
        end
        check(!seen, tag, seen, 0);
    endtask

    task automatic t_reset;
        check(!mem_wr_req && !pc_load && !barrier_bypass, "R1 outputs idle after reset",
              {mem_wr_req, pc_load, barrier_bypass}, 0);
        ext_req = 16'h0008;
        expect_quiet(8, "R1 enable cleared by reset");
        ext_req = '0;
    endtask

    task automatic t_external;
        set_en(1);
        cur_pc = 16'h1234;
        ext_req = 16'h0008;
        wait_save(16'h03F0, 16'h1234, "R2 R7 ext id3");
        ext_req = '0;
        do_jump(16'h3000, "R2 ext id3");
        check(!barrier_bypass, "R5 bypass low when idle", barrier_bypass, 0);
    endtask

    task automatic t_mask;
        set_en(0);
        ext_req = 16'h0008;
        expect_quiet(8, "R7 ext masked when disabled");
        cur_pc = 16'h2222;
        set_en(1);
        wait_save(16'h03F0, 16'h2222, "R7 ext after enable");
        ext_req = '0;
        do_jump(16'h3000, "R7 ext after enable");
        set_en(0);
    endtask

    task automatic t_priority;
        cur_pc = 16'h4444;
        pulse_fault(16'h0220);
        wait_save(16'h05F0, 16'h4444, "R6 R8 first id5");
        do_jump(16'h5000, "R6 first id5");
        cur_pc = 16'h4555;
        wait_save(16'h09F0, 16'h4555, "R6 R8 sticky id9");
        do_jump(16'h9000, "R6 second id9");
        expect_quiet(6, "R8 pending cleared after dispatch");
    endtask

    task automatic t_null;
        cur_pc = 16'h0777;
        null_op = 1;
        @(negedge clk);
        null_op = 0;
        wait_save(16'h06F0, 16'h0777, "R9 null opcode");
        do_jump(16'h6000, "R9 null opcode");
    endtask

    task automatic t_fallback;
        cur_pc = 16'h0B0B;
        pulse_fault(16'h0800);
        wait_save(16'h00F0, 16'h0B0B, "R10 invalid id11");
        do_jump(16'h0100, "R10 invalid id11");
        cfg(4'd3, 2'd2, 16'd0);
        cfg(4'd3, 2'd3, 16'hFFFF);
        cur_pc = 16'h0C0C;
        pulse_fault(16'h0008);
        wait_save(16'h00F0, 16'h0C0C, "R2 R10 cleared valid id3");
        do_jump(16'h0100, "R2 R10 cleared valid id3");
    endtask

    task automatic t_busy_write;
        cur_pc = 16'h0D0D;
        pulse_fault(16'h0020);
        for (int i = 0; i < 20 && !mem_wr_req; i++) @(negedge clk);
        cfg(4'd5, 2'd0, 16'hBEEF);
        cfg(4'd5, 2'd1, 16'hCAFE);
        check(mem_wr_addr == 16'h05F0, "R11 save addr unchanged", mem_wr_addr, 16'h05F0);
        do_jump(16'h5000, "R11 busy write");
        cur_pc = 16'h0E0E;
        pulse_fault(16'h0020);
        wait_save(16'h05F0, 16'h0E0E, "R11 entry kept after busy write");
        do_jump(16'h5000, "R11 entry kept after busy write");
    endtask

    initial begin
        cyc(3);
        rst = 0;
        @(negedge clk);
        t_reset();
        prog(4'd0, 16'h0100, 16'h00F0);
        prog(4'd3, 16'h3000, 16'h03F0);
        prog(4'd5, 16'h5000, 16'h05F0);
        prog(4'd6, 16'h6000, 16'h06F0);
        prog(4'd9, 16'h9000, 16'h09F0);
        t_external();
        t_mask();
        t_priority();
        t_null();
        t_fallback();
        t_busy_write();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule